// File: doc/BRIEF.md
# Double-Buffered Serial Master Controller

This block is a byte-wide SPI master that sits on a simple CPU register port. Software picks the clock polarity, the clock phase, the bit order and one of seven bit rates. It enables the block and then writes bytes to a transmit register. Each byte written is shifted out on MOSI while a byte is shifted in from MISO at the same time. The received byte is placed in a receive register for the CPU to read. The block has no chip-select output. Software selects the slave through general-purpose pins of its own.

Both data paths are two deep. The transmit side holds one byte in the shifter and one byte waiting behind it. The receive side holds the visible byte and one byte waiting behind it. A flag marks each byte that becomes visible, and an optional interrupt follows that flag. A byte that finishes while the visible slot is still unread goes to the waiting slot. Its flag is raised only when a CPU read moves it forward. When both receive slots are full, the master stalls before the next byte, so no received data is lost.

SCK is produced from the system clock (16 MHz by default) by a half-period counter. The counter's limit comes from the rate code.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, the register at 0x524 reads 0x04000000. The registers at 0x108, 0x304, 0x500, 0x518 and 0x554 read 0. Whenever no byte is being shifted, SCK sits at the polarity level and MOSI is 0.
- R2: Writing a byte to 0x51C while the block is enabled queues that byte. Up to two bytes may be queued, and they go out in the order they were written. A write made while two bytes are already queued is ignored, and so is a write made while the block is disabled. Shifting starts whenever a queued byte exists and the shifter is free.
- R3: Register 0x554 bit 2 sets the polarity: 0 means SCK idles low, 1 means SCK idles high. Bit 1 sets the phase. With phase 0, data is sampled on the leading SCK edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge.
- R4: Register 0x554 bit 0 sets the bit order: 0 sends the most significant bit first, 1 sends the least significant bit first. The same order applies to received bits.
- R5: The value in 0x524 sets how many system clocks each SCK half-period lasts. That count is CLK_HZ / (2 × rate), with these codes:
  - 0x02000000 selects 125 kbps.
  - 0x04000000 selects 250 kbps.
  - 0x08000000 selects 500 kbps.
  - 0x10000000 selects 1 Mbps.
  - 0x20000000 selects 2 Mbps.
  - 0x40000000 selects 4 Mbps.
  - 0x80000000 selects 8 Mbps.
  - Any other value selects 250 kbps.
- R6: Each finished byte goes into the receive register (read at 0x518, bits 7:0) if that register is empty, and into the waiting slot otherwise. A read of 0x518 returns the visible byte. If a byte is waiting, the read moves that byte into view.
- R7: Bit 0 of 0x108 (the ready flag) is set each time a byte enters the receive register, at the moment it enters. Writing 0 to it clears it. A byte that lands in the waiting slot does not set the flag.
- R8: Writing 1 to bit 2 of 0x304 sets the interrupt enable. Writing 1 to bit 2 of 0x308 clears it. Both addresses read the enable back in bit 2. The irq output equals the ready flag ANDed with the enable.
- R9: While both receive slots are full, no new byte starts and SCK stays idle. Shifting resumes after the CPU reads 0x518.
- R10: The block is enabled only while the low four bits of 0x500 equal 1. Disabling it stops any byte in progress and empties both queues. It also returns SCK and MOSI to their idle levels, and nothing resumes when the block is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | AW | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of 0x518 consumes the byte) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong receive-slot state would show up at the ports in one of two ways. Either a byte read from 0x518 would be a repeat or out of order, or SCK would keep toggling when both slots are full; either is visible on the first read after the affected byte. A wrong edge counter or phase state would corrupt the bit pattern the slave model captures within the same byte, and would leave SCK away from its idle level after the byte ends. A wrong rate decode changes the measured SCK half-period from the second edge onward. A missing or early ready flag is seen on the register poll at the point where a waiting byte should or should not have moved forward.

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
  parameter int CLK_HZ = 16_000_000,
  parameter int AW     = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          sck,
  output logic          mosi,
  input  logic          miso
);

  localparam logic [AW-1:0] A_READY  = AW'(12'h108);
  localparam logic [AW-1:0] A_IESET  = AW'(12'h304);
  localparam logic [AW-1:0] A_IECLR  = AW'(12'h308);
  localparam logic [AW-1:0] A_ENABLE = AW'(12'h500);
  localparam logic [AW-1:0] A_RXD    = AW'(12'h518);
  localparam logic [AW-1:0] A_TXD    = AW'(12'h51C);
  localparam logic [AW-1:0] A_FREQ   = AW'(12'h524);
  localparam logic [AW-1:0] A_CFG    = AW'(12'h554);
  localparam int DIVW = $clog2(CLK_HZ / 250_000 + 1);

  function automatic int half_for(input logic [31:0] code);
    case (code)
      32'h0200_0000: return CLK_HZ / 250_000;
      32'h0400_0000: return CLK_HZ / 500_000;
      32'h0800_0000: return CLK_HZ / 1_000_000;
      32'h1000_0000: return CLK_HZ / 2_000_000;
      32'h2000_0000: return CLK_HZ / 4_000_000;
      32'h4000_0000: return CLK_HZ / 8_000_000;
      32'h8000_0000: return CLK_HZ / 16_000_000;
      default:       return CLK_HZ / 500_000;
    endcase
  endfunction

  logic [3:0]  en_q;
  logic [31:0] freq_q;
  logic [2:0]  cfg_q;
  logic        int_en, ready_q;
  logic [7:0]  txq0, txq1;
  logic [1:0]  tx_cnt;
  logic [7:0]  rxd_q, rxp_q;
  logic        rxd_v, rxp_v;
  logic        busy, fin, sck_ph;
  logic [4:0]  edg;
  logic [DIVW-1:0] div;
  logic [7:0]  tx_sh, rx_sh;

  wire enabled = (en_q == 4'd1);
  wire order   = cfg_q[0];
  wire cpha    = cfg_q[1];
  wire cpol    = cfg_q[2];

  wire [DIVW-1:0] half_m1 = DIVW'(half_for(freq_q) - 1);
  wire start  = enabled && !busy && !fin && (tx_cnt != 2'd0) && !(rxd_v && rxp_v);
  wire tick   = busy && (div == half_m1);
  wire samp   = tick && (edg[0] == cpha);
  wire push   = reg_wr && reg_addr == A_TXD && enabled && tx_cnt != 2'd2;
  wire rd_pop = reg_rd && reg_addr == A_RXD && rxd_v;
  wire moved  = (rd_pop && rxp_v) || (fin && (!rxd_v || (rd_pop && !rxp_v)));

  wire [2:0] out_idx  = cpha ? 3'((edg - 5'd1) >> 1) : 3'(edg >> 1);
  wire [2:0] in_idx   = 3'(edg >> 1);
  wire [2:0] out_bit  = order ? out_idx : 3'd7 - out_idx;
  wire [2:0] in_bit   = order ? in_idx : 3'd7 - in_idx;

  assign sck  = cpol ^ sck_ph;
  assign mosi = busy && !(cpha && edg == 5'd0) && tx_sh[out_bit];
  assign irq  = ready_q & int_en;

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      freq_q <= 32'h0400_0000;
      cfg_q  <= '0;
      int_en <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_ENABLE: en_q   <= reg_wdata[3:0];
        A_FREQ:   freq_q <= reg_wdata;
        A_CFG:    cfg_q  <= reg_wdata[2:0];
        A_IESET:  if (reg_wdata[2]) int_en <= 1'b1;
        A_IECLR:  if (reg_wdata[2]) int_en <= 1'b0;
        default: ;
      endcase
    end
  end

  // shift engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; fin <= 1'b0; sck_ph <= 1'b0;
      edg <= '0; div <= '0; tx_sh <= '0; rx_sh <= '0;
    end else if (!enabled) begin
      busy <= 1'b0; fin <= 1'b0; sck_ph <= 1'b0;
      edg <= '0; div <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        busy <= 1'b1; tx_sh <= txq0; rx_sh <= '0;
        edg <= '0; div <= '0; sck_ph <= 1'b0;
      end else if (tick) begin
        div    <= '0;
        sck_ph <= ~sck_ph;
        edg    <= edg + 5'd1;
        if (samp) rx_sh[in_bit] <= miso;
        if (edg == 5'd15) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end else if (busy) begin
        div <= div + 1'b1;
      end
    end
  end

  // transmit queue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt <= '0; txq0 <= '0; txq1 <= '0;
    end else if (!enabled) begin
      tx_cnt <= '0;
    end else begin
      case ({start, push})
        2'b11: begin
          txq0 <= (tx_cnt == 2'd1) ? reg_wdata[7:0] : txq1;
          txq1 <= reg_wdata[7:0];
        end
        2'b10: begin
          txq0   <= txq1;
          tx_cnt <= tx_cnt - 2'd1;
        end
        2'b01: begin
          if (tx_cnt == 2'd0) txq0 <= reg_wdata[7:0];
          else                txq1 <= reg_wdata[7:0];
          tx_cnt <= tx_cnt + 2'd1;
        end
        default: ;
      endcase
    end
  end

  // receive slots and ready flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q <= '0; rxp_q <= '0; rxd_v <= 1'b0; rxp_v <= 1'b0; ready_q <= 1'b0;
    end else begin
      if (!enabled) begin
        rxd_v <= 1'b0;
        rxp_v <= 1'b0;
      end else if (rd_pop) begin
        if (rxp_v) begin
          rxd_q <= rxp_q;
          if (fin) rxp_q <= rx_sh;
          else     rxp_v <= 1'b0;
        end else if (fin) begin
          rxd_q <= rx_sh;
        end else begin
          rxd_v <= 1'b0;
        end
      end else if (fin) begin
        if (!rxd_v) begin
          rxd_q <= rx_sh;
          rxd_v <= 1'b1;
        end else begin
          rxp_q <= rx_sh;
          rxp_v <= 1'b1;
        end
      end
      if (enabled && moved)                    ready_q <= 1'b1;
      else if (reg_wr && reg_addr == A_READY)  ready_q <= reg_wdata[0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_READY:          reg_rdata = {31'd0, ready_q};
      A_IESET, A_IECLR: reg_rdata = {29'd0, int_en, 2'b00};
      A_ENABLE:         reg_rdata = {28'd0, en_q};
      A_RXD:            reg_rdata = {24'd0, rxd_q};
      A_FREQ:           reg_rdata = freq_q;
      A_CFG:            reg_rdata = {29'd0, cfg_q};
      default:          reg_rdata = 32'd0;
    endcase
  end

  assert_no_rx_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !(rxd_v && rxp_v));

  assert_push_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> tx_cnt != 2'd0);

  assert_ready_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(fin || rd_pop || (reg_wr && reg_addr == A_READY && reg_wdata[0])));

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol && !mosi));

  assert_fin_after_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !busy && $past(busy));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> !busy && tx_cnt == 2'd0 && !rxd_v);

endmodule

// File: tb/tb_spi_dbuf_master.sv
module tb_spi_dbuf_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, sck, mosi, miso;

  spi_dbuf_master dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  int nvec = 0, nbad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // slave model
  logic       s_cpol = 1'b0, s_cpha = 1'b0, s_order = 1'b0, s_clr = 1'b1;
  logic [7:0] s_dat [8];
  logic [7:0] s_cap [8];
  logic [7:0] s_acc = '0;
  logic       s_prev_sck = 1'b0, s_prev_mosi = 1'b0;
  int s_edge = 0, s_bits = 0, s_nb = 0, s_ncap = 0, s_gap = 0, s_last = 0, cyc = 0;

  function automatic logic pick(input logic [7:0] b, input int e, input logic ph, input logic ord);
    int idx;
    idx = ph ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
    return ord ? b[idx] : b[7 - idx];
  endfunction

  assign miso = pick(s_dat[s_nb % 8], s_edge, s_cpha, s_order);

  always @(negedge clk) begin
    cyc++;
    if (s_clr) begin
      s_edge = 0; s_bits = 0; s_nb = 0; s_ncap = 0; s_gap = 0;
    end else if (sck !== s_prev_sck) begin
      if (s_edge != 0) s_gap = cyc - s_last;
      s_last = cyc;
      if ((sck != s_cpol) ^ s_cpha) begin
        s_acc = s_order ? {s_prev_mosi, s_acc[7:1]} : {s_acc[6:0], s_prev_mosi};
        s_bits++;
        if (s_bits == 8) begin
          s_cap[s_ncap % 8] = s_acc;
          s_ncap++;
          s_bits = 0;
        end
      end
      s_edge = (s_edge == 15) ? 0 : s_edge + 1;
      if (s_edge == 0) s_nb++;
    end
    s_prev_sck = sck;
    s_prev_mosi = mosi;
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_ready(input string req);
    logic [31:0] v;
    int n = 0;
    v = 0;
    while (v[0] !== 1'b1 && n < 4000) begin
      rd(12'h108, v);
      n++;
    end
    chk(req, {31'd0, v[0]}, 32'd1);
  endtask

  // {cfg[7:0], freq[31:0], tx[7:0], slave[7:0], half[7:0]}; cfg = {cpol, cpha, order}
  localparam logic [63:0] VEC [8] = '{
    {8'h00, 32'h8000_0000, 8'hA5, 8'h3C, 8'd1},
    {8'h03, 32'h4000_0000, 8'h1E, 8'hC3, 8'd2},
    {8'h04, 32'h2000_0000, 8'h81, 8'h7E, 8'd4},
    {8'h07, 32'h1000_0000, 8'h6B, 8'h94, 8'd8},
    {8'h01, 32'h0800_0000, 8'hF0, 8'h0F, 8'd16},
    {8'h06, 32'h1234_5678, 8'h5A, 8'hA5, 8'd32},
    {8'h02, 32'h0200_0000, 8'h96, 8'h69, 8'd64},
    {8'h05, 32'h0400_0000, 8'hC8, 8'h37, 8'd32}
  };

  task automatic setup(input logic [2:0] cfg, input logic [31:0] f);
    s_clr = 1'b1;
    wr(12'h500, 0);
    wr(12'h554, {29'd0, cfg});
    wr(12'h524, f);
    s_cpol = cfg[2]; s_cpha = cfg[1]; s_order = cfg[0];
    wr(12'h500, 1);
    wr(12'h108, 0);
    repeat (2) @(negedge clk);
    s_clr = 1'b0;
    @(negedge clk);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++; nvec++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 8; i++) s_dat[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h524, v); chk("R1 freq reset", v, 32'h0400_0000);
    rd(12'h554, v); chk("R1 config reset", v, 0);
    rd(12'h500, v); chk("R1 enable reset", v, 0);
    rd(12'h108, v); chk("R1 ready reset", v, 0);
    rd(12'h518, v); chk("R1 rxd reset", v, 0);
    rd(12'h304, v); chk("R1 inten reset", v, 0);
    chk("R1 idle lines", {29'd0, sck, mosi, irq}, 0);

    // R2 write while disabled is ignored
    s_clr = 1'b0;
    wr(12'h51C, 32'h55);
    repeat (20) @(negedge clk);
    wr(12'h500, 1);
    repeat (700) @(negedge clk);
    chk("R2 disabled write ignored", 32'(s_ncap), 0);
    chk("R2 disabled write no sck", {31'd0, sck}, 0);

    // table of single-byte transfers: R3 R4 R5 R6
    for (int k = 0; k < 8; k++) begin
      logic [63:0] t;
      t = VEC[k];
      s_dat[0] = t[15:8];
      setup(t[58:56], t[55:24]);
      chk("R3 idle polarity", {31'd0, sck}, {31'd0, t[58]});
      wr(12'h51C, {24'd0, t[23:16]});
      wait_ready("R7 ready after byte");
      rd(12'h518, v);
      chk("R6 R4 received byte", v, {24'd0, t[15:8]});
      chk("R3 R4 sent byte", {24'd0, s_cap[0]}, {24'd0, t[23:16]});
      chk("R2 one byte only", 32'(s_ncap), 1);
      chk("R5 half period", 32'(s_gap), {24'd0, t[7:0]});
      chk("R1 idle after byte", {30'd0, sck, mosi}, {30'd0, t[58], 1'b0});
    end

    // double buffering, deferred ready, hold, interrupt: R2 R6 R7 R8 R9
    s_dat[0] = 8'hD1; s_dat[1] = 8'hD2; s_dat[2] = 8'hD3; s_dat[3] = 8'hD4;
    setup(3'b000, 32'h8000_0000);
    wr(12'h304, 4);
    rd(12'h304, v); chk("R8 enable readback", v, 4);
    wr(12'h51C, 32'h11);
    wr(12'h51C, 32'h22);
    wr(12'h51C, 32'h33);
    wr(12'h51C, 32'h44);
    repeat (200) @(negedge clk);
    chk("R9 hold with both slots full", 32'(s_ncap), 2);
    rd(12'h108, v); chk("R7 ready first byte", v, 1);
    chk("R8 irq asserted", {31'd0, irq}, 1);
    wr(12'h108, 0);
    repeat (10) @(negedge clk);
    rd(12'h108, v); chk("R7 pending byte sets no ready", v, 0);
    chk("R8 irq follows ready", {31'd0, irq}, 0);
    rd(12'h518, v); chk("R6 first byte", v, 32'hD1);
    rd(12'h108, v); chk("R7 ready on move", v, 1);
    wr(12'h308, 4);
    chk("R8 irq cleared by disable bit", {31'd0, irq}, 0);
    rd(12'h308, v); chk("R8 clear readback", v, 0);
    repeat (200) @(negedge clk);
    chk("R9 resume after read", 32'(s_ncap), 3);
    wr(12'h108, 0);
    rd(12'h518, v); chk("R6 second byte", v, 32'hD2);
    rd(12'h108, v); chk("R7 ready on second move", v, 1);
    rd(12'h518, v); chk("R6 third byte", v, 32'hD3);
    wr(12'h108, 0);
    rd(12'h518, v);
    rd(12'h108, v); chk("R7 no ready when empty", v, 0);
    repeat (200) @(negedge clk);
    chk("R2 write to full queue ignored", 32'(s_ncap), 3);
    chk("R2 order byte 0", {24'd0, s_cap[0]}, 32'h11);
    chk("R2 order byte 1", {24'd0, s_cap[1]}, 32'h22);
    chk("R2 order byte 2", {24'd0, s_cap[2]}, 32'h33);

    // R10 abort on disable
    setup(3'b100, 32'h0200_0000);
    wr(12'h51C, 32'hFF);
    wr(12'h51C, 32'h00);
    repeat (300) @(negedge clk);
    wr(12'h500, 0);
    @(negedge clk);
    chk("R10 idle after abort", {30'd0, sck, mosi}, 32'd2);
    wr(12'h500, 1);
    repeat (2500) @(negedge clk);
    chk("R10 no resume sck", {31'd0, sck}, 1);
    chk("R10 no full byte", 32'(s_ncap), 0);
    rd(12'h108, v); chk("R10 no ready", v, 0);

    // R10 enable needs value 1 in the low bits
    wr(12'h500, 3);
    wr(12'h51C, 32'h77);
    repeat (100) @(negedge clk);
    chk("R10 value 3 stays disabled", {31'd0, sck}, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule